// File: doc/BRIEF.md
# Packed Decimal Add/Subtract Unit

This block adds or subtracts two packed BCD numbers of a parameterised number of digits. Each digit has its own slice. A slice holds a 4-bit binary adder and decimal-carry correction logic. The carry from each slice ripples into the next, from the least significant digit to the most significant. In subtract mode each subtrahend digit first passes through a nines-complement generator, and the carry into the lowest slice is forced to 1. The same adder chain therefore forms the tens-complement difference.

A small controller frames each operation. In the idle state `IDLE`, a `start` pulse latches both operands and the mode, and the controller moves to `EVAL` (transition IDLE→EVAL). In `EVAL` the ripple chain settles and its result and carry are captured, and the controller moves to `DONE` (transition EVAL→DONE). `DONE` raises `done` for exactly one cycle and then returns to `IDLE` (transition DONE→IDLE). Any `start` seen outside `IDLE` is ignored. In subtract mode, a carry-out of 1 means the difference is non-negative. A carry-out of 0 means the result digits are the tens complement of a negative difference.

Top module: `bcd_addsub_unit`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `busy`, `done`, `result` and `carry_out` are all 0.
- R2: With `sub`=0, `result` equals (A+B) mod 10^DIGITS in packed BCD, and `carry_out` is 1 exactly when A+B ≥ 10^DIGITS. Digit i sits in bits [4i+3:4i].
- R3: With `sub`=1, `result` equals (A−B+10^DIGITS) mod 10^DIGITS, and `carry_out` is 1 exactly when A ≥ B.
- R4: A digit slice whose binary sum is between 10 and 19 yields that sum minus 10 and passes a carry to the next digit, so 9+7 gives digit 6 with carry and 9+9 gives digit 8 with carry.
- R5: Carries ripple through every digit, so 9999+0001 gives 0000 with `carry_out`=1.
- R6: The nines complement of each subtrahend digit is 9 minus that digit, so 0−7 gives 9993 with `carry_out`=0 (the complement of 7 is 2).
- R7: When `start` is sampled high in IDLE, `busy` is high for the next two cycles and `done` is high in only the second of them.
- R8: A `start` sampled while `busy` is high does not change the operation in flight or its result.
- R9: `result` and `carry_out` change only on the edge that enters DONE, and they hold between operations.
- R10: When both operands are valid BCD, every result digit is 9 or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted in IDLE only) |
| sub | input | 1 | 0 = add, 1 = subtract (B from A) |
| a | input | 4*DIGITS | Operand A, packed BCD |
| b | input | 4*DIGITS | Operand B, packed BCD |
| busy | output | 1 | High in EVAL and DONE |
| done | output | 1 | One-cycle pulse with a new result |
| result | output | 4*DIGITS | Result digits, packed BCD |
| carry_out | output | 1 | Decimal carry out of the top digit |

## Verification
The bench targets digit sums of exactly 10, 16 and 19. A slice whose correction term is wrong would leave a binary value such as 1010 or 1101 in the digit, or would drop the carry into the next digit. Full-length carry chains such as 9999+0001 and 0000−0001 expose a break in the ripple path, which would show up as a wrong top digit or a wrong `carry_out`. Subtractions with A<B, A=B and A>B check the tens-complement carry sense, and a missing initial carry would leave every difference one low. A `start` pulsed in mid-operation with different operands checks that the latched operands are protected.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_DONE = 2'd2
    } ctl_state_t;

    localparam logic [3:0] NINES_ADJ = 4'b1010;
    localparam logic [3:0] DEC_ADJ   = 4'b0110;
endpackage

// File: rtl/bcd_nines.sv
module bcd_nines (
    input  logic       en,
    input  logic [3:0] digit_in,
    output logic [3:0] digit_out
);
    import bcd_pkg::*;
    logic [3:0] flipped;
    always_comb begin
        flipped   = ~digit_in;
        digit_out = en ? (flipped + NINES_ADJ) : digit_in;
    end
endmodule

// File: rtl/bcd_digit_slice.sv
module bcd_digit_slice (
    input  logic [3:0] x,
    input  logic [3:0] y,
    input  logic       cin,
    output logic [3:0] sum,
    output logic       cout
);
    import bcd_pkg::*;
    logic [4:0] raw;
    logic       k;
    logic [3:0] z;
    always_comb begin
        raw  = {1'b0, x} + {1'b0, y} + {4'b0, cin};
        k    = raw[4];
        z    = raw[3:0];
        cout = k | (z[3] & z[2]) | (z[3] & z[1]);
        sum  = cout ? (z + DEC_ADJ) : z;
    end
endmodule

// File: rtl/bcd_ripple_chain.sv
module bcd_ripple_chain #(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic         sub,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [DIGITS:0] carry;
    assign carry[0] = sub;
    assign cout     = carry[DIGITS];

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [3:0] yd;
        bcd_nines u_nines (
            .en       (sub),
            .digit_in (opb[4*i +: 4]),
            .digit_out(yd)
        );
        bcd_digit_slice u_slice (
            .x   (opa[4*i +: 4]),
            .y   (yd),
            .cin (carry[i]),
            .sum (sum[4*i +: 4]),
            .cout(carry[i+1])
        );
    end
endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit #(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         sub,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result,
    output logic         carry_out
);
    import bcd_pkg::*;

    ctl_state_t   state, state_nx;
    logic [W-1:0] a_q, b_q;
    logic         sub_q;
    logic [W-1:0] chain_sum;
    logic         chain_cout;

    bcd_ripple_chain #(.DIGITS(DIGITS)) u_chain (
        .sub (sub_q),
        .opa (a_q),
        .opb (b_q),
        .sum (chain_sum),
        .cout(chain_cout)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_EVAL;
            ST_EVAL: state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q       <= '0;
            b_q       <= '0;
            sub_q     <= 1'b0;
            result    <= '0;
            carry_out <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    a_q   <= a;
                    b_q   <= b;
                    sub_q <= sub;
                end
                ST_EVAL: begin
                    result    <= chain_sum;
                    carry_out <= chain_cout;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
    end
endmodule

// File: rtl/bcd_addsub_unit_chk.sv
module bcd_addsub_unit_chk #(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic [W-1:0] a_q,
    input logic [W-1:0] b_q,
    input logic         sub_q
);
    function automatic logic all_bcd(input logic [W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DIGITS; i++)
            if (v[4*i +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(result) || !$stable(carry_out)) |-> done);

    // R10
    digit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && all_bcd(a_q) && all_bcd(b_q)) |-> all_bcd(result));

    // R3
    sub_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sub_q && all_bcd(a_q) && all_bcd(b_q)) |-> (carry_out == (a_q >= b_q)));
endmodule

bind bcd_addsub_unit bcd_addsub_unit_chk #(.DIGITS(DIGITS)) u_chk (.*);

// File: tb/bcd_addsub_unit_test.sv
module bcd_addsub_unit_test;
    localparam int DIGITS = 4;
    localparam int W = 4 * DIGITS;
    localparam int MODV = 10 ** DIGITS;

    logic clk = 0, rst_n = 0, start = 0, sub = 0;
    logic [W-1:0] a = '0, b = '0;
    logic busy, done, carry_out;
    logic [W-1:0] result;

    int compared = 0, mismatched = 0;

    typedef struct {
        logic [W-1:0] res;
        logic         cy;
        string        req;
    } exp_t;
    exp_t sbq[$];

    always #5 clk = ~clk;

    bcd_addsub_unit #(.DIGITS(DIGITS)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sub(sub),
        .a(a), .b(b), .busy(busy), .done(done),
        .result(result), .carry_out(carry_out)
    );

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] r;
        int t;
        t = v;
        for (int i = 0; i < DIGITS; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    function automatic int from_bcd(input logic [W-1:0] v);
        int r;
        r = 0;
        for (int i = DIGITS - 1; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
        return r;
    endfunction

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pop expected item whenever a result is flagged
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                check("R7 unexpected done", {1'b1, {W{1'b0}}}, '0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(e.req, {carry_out, result}, {e.cy, e.res});
            end
        end
    end

    task automatic run_op(input int av, input int bv, input logic s, input string req,
                          input logic poke);
        exp_t e;
        int d;
        @(negedge clk);
        a = to_bcd(av); b = to_bcd(bv); sub = s; start = 1;
        if (s) begin
            d = av - bv;
            e.cy = (av >= bv);
            e.res = to_bcd((d + MODV) % MODV);
        end else begin
            d = av + bv;
            e.cy = (d >= MODV);
            e.res = to_bcd(d % MODV);
        end
        e.req = req;
        sbq.push_back(e);
        @(negedge clk);
        start = poke;
        if (poke) begin
            a = to_bcd(1234); b = to_bcd(4321); sub = ~s; // R8 ignored while busy
        end
        check("R7 busy/done in EVAL", {{(W-1){1'b0}}, busy, done}, {{(W-1){1'b0}}, 2'b10});
        @(negedge clk);
        check("R7 busy/done in DONE", {{(W-1){1'b0}}, busy, done}, {{(W-1){1'b0}}, 2'b11});
        start = 0;
        @(negedge clk);
        check("R9 result held after DONE", {carry_out, result}, {e.cy, e.res});
        check("R7 idle after DONE", {{(W-1){1'b0}}, busy, done}, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset held", {busy, done, carry_out, result[W-2:0]}, '0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after release", {busy, done, carry_out, result[W-2:0]}, '0);
        run_op(9, 7, 0, "R4 9+7", 0);
        run_op(9, 9, 0, "R4 9+9", 0);
        run_op(5, 5, 0, "R4 sum of 10", 0);
        run_op(9999, 1, 0, "R5 ripple add", 0);
        run_op(9999, 9999, 0, "R2 max add", 0);
        run_op(0, 7, 1, "R6 0-7", 0);
        run_op(0, 1, 1, "R5 ripple borrow", 0);
        run_op(4567, 4567, 1, "R3 equal sub", 0);
        run_op(8000, 123, 1, "R3 positive sub", 0);
        run_op(123, 8000, 1, "R3 negative sub", 0);
        run_op(2468, 1357, 0, "R8 start while busy", 1);
        run_op(500, 499, 1, "R8 start while busy sub", 1);
        for (int i = 0; i < 40; i++) begin
            int x, y;
            x = int'($urandom % MODV);
            y = int'($urandom % MODV);
            run_op(x, y, i[0], i[0] ? "R3 random sub" : "R2 random add", 0);
        end
        for (int i = 0; i < 20; i++) begin
            int x, y, r;
            x = int'($urandom % MODV);
            y = int'($urandom % MODV);
            run_op(x, y, 0, "R10 add digits", 0);
            r = from_bcd(result);
            check("R10 digits valid", {{W{1'b0}}, (result == to_bcd(r))}, {{W{1'b0}}, 1'b1});
        end
        check("R7 scoreboard drained", {{(W-1){1'b0}}, 2'(sbq.size())}, '0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule